// File: doc/BRIEF.md
# Next-Fetch-Address and Link Unit

This unit keeps the fetch address of a 32-bit RISC front end that uses fixed four-byte instructions. In each cycle it receives the decoded control-flow class of the instruction at the current fetch address. That class is one of plain, branch, call or return, and it comes with an address-mode bit, a taken flag, a target or offset field and a register-supplied return address. From these inputs the unit produces the next fetch address.

Every redirect is delayed by one instruction. The instruction that follows a taken branch, a call or a return is fetched in the normal sequence and always executes. The captured destination takes effect only after that delay-slot fetch. A one-entry pending register holds the destination across the slot.

For a call, the unit also emits a one-cycle write strobe with a link value. The link value points past the delay slot, so that a later return resumes at the right instruction.

Top module: `nextpc_link`

## Requirements
- R1: On an advancing cycle (stepEn=1) with no pending redirect and no accepted request, fetchPc increases by 4 at the next clock edge. A branch with taken=0 counts as no request.
- R2: The destination mode is chosen per instruction. With absMode=1 the destination is targetIn itself. With absMode=0 the destination is the low 16 bits of targetIn, sign-extended, multiplied by 4 and added to the address of the delay-slot instruction (request address + 4).
- R3: When a taken branch, a call or a return is accepted at address P, the next fetchPc is P+4 (the delay slot). The fetch after that is the captured destination.
- R4: Control inputs presented while the delay slot is being fetched are ignored. The redirect still goes to the destination captured earlier, and sequential fetch resumes from there.
- R5: A call is unconditional, whatever the value of taken, and uses the same delayed transfer and destination modes as a branch.
- R6: An accepted call raises linkWe for exactly one cycle after the call edge, with linkData = P+8, the address just past the delay slot.
- R7: An accepted return is unconditional. Its destination is retAddr, regardless of absMode.
- R8: A synchronous active-high reset sets fetchPc to 0, drops linkWe and discards any pending redirect.
- R9: When stepEn=0, fetchPc and any pending redirect are held, requests are ignored and linkWe stays low.
- R10: When several requests are raised at once, return has priority over call, and call has priority over branch. A call that loses to a return writes no link.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stepEn | input | 1 | Fetch advances this cycle |
| branchReq | input | 1 | Instruction at fetchPc is a branch |
| callReq | input | 1 | Instruction at fetchPc is a call |
| retReq | input | 1 | Instruction at fetchPc is a return |
| taken | input | 1 | Branch condition result |
| absMode | input | 1 | 1: absolute destination, 0: word offset |
| targetIn | input | 32 | Absolute destination or offset field |
| retAddr | input | 32 | Return address read from a register |
| fetchPc | output | 32 | Address of the instruction being fetched |
| linkData | output | 32 | Return address to write to the link register |
| linkWe | output | 1 | One-cycle link write strobe |

## Verification
A pending flag stuck high or low shows at the ports within two fetches. A stuck-low flag skips the redirect, so sequential fetch continues past the slot. A stuck-high flag either reloads a stale destination or swallows the next branch. An error in the offset arithmetic or the mode select appears at fetchPc exactly two advancing cycles after the request. An error in the link path appears on linkData in the cycle right after the call. A leaking stall shows as fetchPc moving while stepEn is low.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;
  typedef struct packed {
    logic advance;    // sequential step
    logic capture;    // latch destination into pending register
    logic redirect;   // load pending destination into PC
    logic writeLink;  // latch link value
    logic selRet;     // destination from return register
    logic selAbs;     // absolute destination
  } pcCtrl_t;
endpackage

// File: rtl/nextpc_ctrl.sv
module nextpc_ctrl
  import nextpc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    stepEn,
  input  logic    branchReq,
  input  logic    callReq,
  input  logic    retReq,
  input  logic    taken,
  input  logic    absMode,
  output pcCtrl_t ctrl,
  output logic    linkWe
);
  logic pendValid;
  logic anyReq;
  logic accept;

  assign anyReq = retReq | callReq | (branchReq & taken);
  assign accept = stepEn & ~pendValid & anyReq;

  always_comb begin
    ctrl           = '0;
    ctrl.advance   = stepEn & ~pendValid;
    ctrl.capture   = accept;
    ctrl.redirect  = stepEn & pendValid;
    ctrl.writeLink = accept & callReq & ~retReq;
    ctrl.selRet    = retReq;
    ctrl.selAbs    = absMode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendValid <= 1'b0;
      linkWe    <= 1'b0;
    end else begin
      linkWe <= ctrl.writeLink;
      if (ctrl.capture)
        pendValid <= 1'b1;
      else if (ctrl.redirect)
        pendValid <= 1'b0;
    end
  end
endmodule

// File: rtl/nextpc_path.sv
module nextpc_path
  import nextpc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int OFS_W = 16,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  pcCtrl_t         ctrl,
  input  logic [XLEN-1:0] targetIn,
  input  logic [XLEN-1:0] retAddr,
  output logic [XLEN-1:0] fetchPc,
  output logic [XLEN-1:0] linkData
);
  localparam int INST_BYTES = 4;
  localparam int WORD_SHIFT = $clog2(INST_BYTES);

  logic [XLEN-1:0] pcQ, tgtQ, linkQ;
  logic [XLEN-1:0] seqPc, ofsExt, ofsBytes, relTgt, dest;

  generate
    if (OFS_W < XLEN) begin : g_sext
      assign ofsExt = {{(XLEN-OFS_W){targetIn[OFS_W-1]}}, targetIn[OFS_W-1:0]};
    end else begin : g_full
      assign ofsExt = targetIn;
    end
  endgenerate

  assign seqPc    = pcQ + XLEN'(INST_BYTES);
  assign ofsBytes = ofsExt << WORD_SHIFT;
  assign relTgt   = seqPc + ofsBytes;
  assign dest     = ctrl.selRet ? retAddr : (ctrl.selAbs ? targetIn : relTgt);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ   <= RESET_PC;
      tgtQ  <= '0;
      linkQ <= '0;
    end else begin
      if (ctrl.redirect)
        pcQ <= tgtQ;
      else if (ctrl.advance)
        pcQ <= seqPc;
      if (ctrl.capture)
        tgtQ <= dest;
      if (ctrl.writeLink)
        linkQ <= seqPc + XLEN'(INST_BYTES);
    end
  end

  assign fetchPc  = pcQ;
  assign linkData = linkQ;
endmodule

// File: rtl/nextpc_link.sv
module nextpc_link
  import nextpc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int OFS_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stepEn,
  input  logic            branchReq,
  input  logic            callReq,
  input  logic            retReq,
  input  logic            taken,
  input  logic            absMode,
  input  logic [XLEN-1:0] targetIn,
  input  logic [XLEN-1:0] retAddr,
  output logic [XLEN-1:0] fetchPc,
  output logic [XLEN-1:0] linkData,
  output logic            linkWe
);
  pcCtrl_t ctrl;

  nextpc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .stepEn(stepEn),
    .branchReq(branchReq), .callReq(callReq), .retReq(retReq),
    .taken(taken), .absMode(absMode),
    .ctrl(ctrl), .linkWe(linkWe)
  );

  nextpc_path #(.XLEN(XLEN), .OFS_W(OFS_W), .RESET_PC('0)) u_path (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .targetIn(targetIn), .retAddr(retAddr),
    .fetchPc(fetchPc), .linkData(linkData)
  );
endmodule

// File: rtl/nextpc_chk.sv
module nextpc_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            stepEn,
  input logic            branchReq,
  input logic            callReq,
  input logic            retReq,
  input logic            taken,
  input logic [XLEN-1:0] fetchPc,
  input logic [XLEN-1:0] linkData,
  input logic            linkWe
);
  // Shadow of "the next advancing fetch is a delay slot redirect"
  logic slotQ;
  logic reqSeen;
  assign reqSeen = retReq | callReq | (branchReq & taken);

  always_ff @(posedge clk) begin
    if (rst)
      slotQ <= 1'b0;
    else if (stepEn && !slotQ && reqSeen)
      slotQ <= 1'b1;
    else if (stepEn && slotQ)
      slotQ <= 1'b0;
  end

  a_r1_sequential: assert property (@(posedge clk) disable iff (rst)
    (stepEn && !slotQ && !reqSeen) |=> fetchPc == $past(fetchPc) + 32'd4);

  a_r3_slot_fetch: assert property (@(posedge clk) disable iff (rst)
    (stepEn && !slotQ && reqSeen) |=> fetchPc == $past(fetchPc) + 32'd4);

  a_r6_link_value: assert property (@(posedge clk) disable iff (rst)
    linkWe |-> linkData == $past(fetchPc) + 32'd8);

  a_r6_link_pulse: assert property (@(posedge clk) disable iff (rst)
    linkWe |=> !linkWe);

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
    !stepEn |=> ($stable(fetchPc) && !linkWe));

  a_r8_reset_state: assert property (@(posedge clk)
    rst |=> (fetchPc == '0 && !linkWe));
endmodule

bind nextpc_link nextpc_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .stepEn(stepEn), .branchReq(branchReq),
  .callReq(callReq), .retReq(retReq), .taken(taken),
  .fetchPc(fetchPc), .linkData(linkData), .linkWe(linkWe)
);

// File: tb/sim_nextpc_link.sv
module sim_nextpc_link;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stepEn = 1'b0, branchReq = 1'b0, callReq = 1'b0, retReq = 1'b0;
  logic taken = 1'b0, absMode = 1'b0;
  logic [31:0] targetIn = '0, retAddr = '0;
  logic [31:0] fetchPc, linkData;
  logic linkWe;

  always #(PERIOD/2) clk = ~clk;

  nextpc_link u0 (
    .clk(clk), .rst(rst), .stepEn(stepEn), .branchReq(branchReq),
    .callReq(callReq), .retReq(retReq), .taken(taken), .absMode(absMode),
    .targetIn(targetIn), .retAddr(retAddr),
    .fetchPc(fetchPc), .linkData(linkData), .linkWe(linkWe)
  );

  typedef struct {
    logic [31:0] pc;
    logic        we;
    logic [31:0] link;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // requirement model
  logic [31:0] mPc = '0;
  logic        mPend = 1'b0;
  logic [31:0] mTgt = '0;

  task automatic step(input string tag, input logic en, input logic br,
                      input logic cl, input logic rt, input logic ab,
                      input logic tk, input logic [31:0] tg, input logic [31:0] ra);
    expItem_t it;
    logic [31:0] ofs;
    @(negedge clk);
    stepEn = en; branchReq = br; callReq = cl; retReq = rt;
    absMode = ab; taken = tk; targetIn = tg; retAddr = ra;
    it.we = 1'b0; it.link = '0; it.tag = tag;
    if (!en) begin
      it.pc = mPc;
    end else if (mPend) begin
      it.pc = mTgt;
      mPend = 1'b0;
    end else begin
      if (rt || cl || (br && tk)) begin
        ofs = {{16{tg[15]}}, tg[15:0]} << 2;
        mTgt = rt ? ra : (ab ? tg : mPc + 32'd4 + ofs);
        mPend = 1'b1;
        if (cl && !rt) begin
          it.we = 1'b1;
          it.link = mPc + 32'd8;
        end
      end
      it.pc = mPc + 32'd4;
    end
    mPc = it.pc;
    expQ.push_back(it);
  endtask

  task automatic idleStep(input string tag);
    step(tag, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
  endtask

  task automatic applyReset();
    @(negedge clk);
    rst = 1'b1; stepEn = 1'b0; branchReq = 1'b0; callReq = 1'b0; retReq = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    mPc = '0; mPend = 1'b0;
    checks++;
    if (fetchPc !== 32'h0 || linkWe !== 1'b0) begin
      errors++;
      $display("FAIL R8 reset: pc=%h we=%b expected pc=00000000 we=0", fetchPc, linkWe);
    end
  endtask

  // monitor
  always @(posedge clk) begin
    #(PERIOD/4);
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      checks++;
      if (fetchPc !== e.pc || linkWe !== e.we || (e.we && linkData !== e.link)) begin
        errors++;
        $display("FAIL %s: pc=%h we=%b link=%h expected pc=%h we=%b link=%h",
                 e.tag, fetchPc, linkWe, linkData, e.pc, e.we, e.link);
      end
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    applyReset();                                  // R8 initial
    idleStep("R1 seq");                            // 0 -> 4
    idleStep("R1 seq");                            // -> 8
    step("R1 not taken", 1,1,0,0,0,0, 32'h5, 0);  // -> 12
    step("R2 R3 rel fwd", 1,1,0,0,0,1, 32'h5, 0); // -> 16, dest 36
    step("R4 slot ignore", 1,1,0,0,1,1, 32'h100, 0); // -> 36
    idleStep("R4 resume");                         // -> 40
    step("R2 rel back", 1,1,0,0,0,1, 32'h0000FFFD, 0); // -> 44, dest 32
    idleStep("R2 rel back dest");                  // -> 32
    step("R2 abs", 1,1,0,0,1,1, 32'h200, 0);       // -> 36
    idleStep("R2 abs dest");                       // -> 0x200
    step("R5 R6 call rel", 1,0,1,0,0,0, 32'h10, 0); // -> 0x204, link 0x208
    idleStep("R5 R6 call dest");                   // -> 0x244, no strobe
    step("R6 call abs", 1,0,1,0,1,0, 32'h400, 0);  // -> 0x248, link 0x24C
    step("R9 stall in slot", 0,1,1,1,1,1, 32'h900, 32'h77); // hold
    step("R9 stall again", 0,0,0,0,0,0, 0, 0);     // hold
    idleStep("R9 resume redirect");                // -> 0x400
    step("R7 ret", 1,0,0,1,1,0, 32'h900, 32'h24C); // -> 0x404
    idleStep("R7 ret dest");                       // -> 0x24C
    step("R10 priority", 1,1,1,1,1,1, 32'h900, 32'h80); // -> 0x250, no link
    idleStep("R10 ret wins");                      // -> 0x80
    step("R8 pend before reset", 1,1,0,0,1,1, 32'h500, 0); // -> 0x84
    @(negedge clk);                                // let monitor drain
    applyReset();                                  // R8 mid-run
    idleStep("R8 pending cleared");                // -> 4
    idleStep("R1 seq after reset");                // -> 8
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule